// File: doc/BRIEF.md
# Interval Timer Tick Ignore Counters

This block thins a shared periodic timer tick into per-CPU interval-timer interrupt requests. It holds one ignore counter for each of four CPUs. Each counter has a 24-bit count and a sticky overflow flag. Every rising edge of the tick decrements the counter of each CPU marked present. Once the count has wrapped past zero, the overflow flag stays set. From then on, every tick raises a one-cycle set pulse toward that CPU's timer-interrupt flag in the interrupt controller.

The count keeps running after the overflow flag is set. Software can therefore read the counter back and work out how many ticks were skipped. Software loads a count through a 64-bit register port, and that write also clears the overflow flag. The tick input may come from another clock domain. It is synchronised and edge-detected inside the block. Building the tick and clearing the interrupt flag are done outside this block.

Top module: `tick_skip_counters`

## Requirements
- R1: After reset, all four counters read 0 (count 0, overflow 0) and no `iti_set_o` bit is high.
- R2: Counter n is reached at byte offsets 0x380, 0x3C0, 0x700 and 0x740 for n = 0..3. An address must match exactly. A read returns the count in bits 23:0, the overflow flag in bit 24 and zeros in bits 63:25. Any other address reads 0, and a write to it changes no counter.
- R3: A write stores write-data bits 23:0 as the count and clears the overflow flag (bit 24). Write-data bits 63:24 are ignored.
- R4: On a tick, a present counter becomes (old − 1) mod 2^25, ORed with the old overflow flag. Count 0 with the flag clear therefore becomes 0x1FFFFFF. Once set, the flag stays set while the count keeps decrementing.
- R5: In the cycle a tick update lands, `iti_set_o[n]` is high for exactly one cycle for each present CPU whose updated overflow flag is set. In all other cycles it is low.
- R6: A counter whose `present_i` bit is low neither changes nor pulses on a tick.
- R7: Only a rising edge of `tick_i` counts. A held high level or a falling edge has no effect. The update lands on the third rising clock edge after `tick_i` goes high.
- R8: If a write to a counter and a tick update fall in the same cycle, the write wins. That counter takes the written value and gives no pulse, while the other counters tick normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic timer tick, asynchronous level |
| present_i | input | 4 | Per-CPU present flags |
| reg_addr_i | input | 12 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational from the address |
| iti_set_o | output | 4 | Per-CPU interval-timer interrupt set pulses |

## Verification
A rise on `tick_i` takes effect three clock edges later: two synchroniser stages and then the counter register. The bench drives the tick at a falling clock edge and counts exactly three rising edges. At the falling edge before the third rising edge, it reads a counter to confirm that nothing has changed yet. At the falling edge after the third rising edge, it checks the pulse pattern. One cycle later it checks that the pulse has dropped. Writes land on the first rising edge after they are driven. Reads are combinational and are sampled 1 ns after the address is set at a falling edge. The collision case places the write strobe in the single cycle where the synchronised edge is live.

// File: rtl/tick_skip_pkg.sv
package tick_skip_pkg;
  localparam int unsigned DEF_CNT_W = 24;
  localparam int unsigned OFS_W     = 16;

  // Pairs of slots start 0x380 apart; slots in a pair are 0x40 apart.
  function automatic logic [OFS_W-1:0] slot_offset(input int unsigned idx);
    int unsigned o;
    o = 32'h380 * (idx / 2 + 1) + 32'h40 * (idx % 2);
    return o[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/tick_rise.sv
module tick_rise #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tick_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R7: a held level yields a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/skip_counter.sv
module skip_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             present_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W:0]   val_o,
  output logic             iti_o
);
  localparam int unsigned    OVF   = CNT_W;
  localparam logic [CNT_W:0] ONE_R = 1;
  localparam logic [CNT_W-1:0] ONE_C = 1;

  logic [CNT_W:0] val_q, dec;
  logic           iti_q, adv;

  always_comb begin
    dec      = val_q - ONE_R;
    dec[OVF] = dec[OVF] | val_q[OVF];
  end

  assign adv = tick_i & present_i & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      iti_q <= 1'b0;
    end else begin
      iti_q <= 1'b0;
      if (wr_i) begin
        val_q <= {1'b0, wdata_i};
      end else if (adv) begin
        val_q <= dec;
        iti_q <= dec[OVF];
      end
    end
  end

  assign val_o = val_q;
  assign iti_o = iti_q;

  a_r3_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> val_q == {1'b0, $past(wdata_i)});
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> val_q[CNT_W-1:0] == $past(val_q[CNT_W-1:0]) - ONE_C);
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_q[OVF] && !wr_i) |=> val_q[OVF]);
  a_r6_absent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!present_i && !wr_i) |=> $stable(val_q));
  a_r5_pulse_needs_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iti_q |-> val_q[OVF]);
  a_r8_write_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !iti_q);
endmodule

// File: rtl/reg_select.sv
module reg_select
  import tick_skip_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned REG_W   = 25,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            we_i,
  input  logic [NUM_CPU-1:0][REG_W-1:0]   vals_i,
  output logic [NUM_CPU-1:0]              wr_o,
  output logic [DATA_W-1:0]               rdata_o
);
  logic [NUM_CPU-1:0] hit;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    localparam logic [OFS_W-1:0] OFS = slot_offset(g);
    assign hit[g]  = (addr_i == OFS[ADDR_W-1:0]);
    assign wr_o[g] = hit[g] & we_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (hit[i]) rdata_o = rdata_o | DATA_W'(vals_i[i]);
    end
  end

  // R2: slot offsets are distinct
  a_r2_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
endmodule

// File: rtl/tick_skip_counters.sv
module tick_skip_counters #(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned CNT_W       = tick_skip_pkg::DEF_CNT_W,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_CPU-1:0] present_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_CPU-1:0] iti_set_o
);
  localparam int unsigned REG_W = CNT_W + 1;

  logic                          tick_rise_w;
  logic [NUM_CPU-1:0]            wr_sel;
  logic [NUM_CPU-1:0][REG_W-1:0] vals;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:CNT_W];

  tick_rise #(.SYNC_STAGES(SYNC_STAGES)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rise_o (tick_rise_w)
  );

  reg_select #(
    .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .vals_i  (vals),
    .wr_o    (wr_sel),
    .rdata_o (reg_rdata_o)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    skip_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_rise_w),
      .present_i (present_i[g]),
      .wr_i      (wr_sel[g]),
      .wdata_i   (reg_wdata_i[CNT_W-1:0]),
      .val_o     (vals[g]),
      .iti_o     (iti_set_o[g])
    );
  end

  // R5: pulses only follow a tick edge
  a_r5_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iti_set_o != '0) |-> $past(tick_rise_w));
endmodule

// File: tb/sim_tick_skip_counters.sv
`timescale 1ns/1ps
module sim_tick_skip_counters;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  present = 4'hF;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [3:0]  iti;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  localparam logic [11:0] OFS [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};
  logic [24:0] mdl [4];

  always #2.5 clk = ~clk;

  tick_skip_counters u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .present_i(present),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .iti_set_o(iti)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [24:0] step(input logic [24:0] v);
    return ((v - 25'd1) & 25'h1FFFFFF) | (v & 25'h1000000);
  endfunction

  task automatic check_state(input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      addr = OFS[i];
      #1;
      chk(req, rdata, {39'b0, mdl[i]});
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    for (int i = 0; i < 4; i++)
      if (OFS[i] == a) mdl[i] = {1'b0, d[23:0]};
  endtask

  task automatic tick_cycle(input bit do_wr, input int wi, input logic [63:0] wd);
    logic [3:0] exp_iti;
    exp_iti = '0;
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (do_wr) begin
      we = 1'b1; addr = OFS[wi]; wdata = wd;
    end else begin
      addr = OFS[0];
      #1;
      chk("R7 update not before third edge", rdata, {39'b0, mdl[0]});
    end
    @(negedge clk);
    we = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (do_wr && i == wi) mdl[i] = {1'b0, wd[23:0]};
      else if (present[i]) begin
        mdl[i] = step(mdl[i]);
        exp_iti[i] = mdl[i][24];
      end
    end
    chk(do_wr ? "R8 pulse pattern" : "R5 pulse pattern", 64'(iti), 64'(exp_iti));
    @(negedge clk);
    chk("R5 pulse one cycle", 64'(iti), 64'd0);
    repeat (6) @(negedge clk);
    check_state(do_wr ? "R8 values" : "R4 R6 R7 level held");
    tick = 1'b0;
    repeat (6) @(negedge clk);
    check_state("R7 falling edge ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_state("R1 reset value");
    chk("R1 no pulse", 64'(iti), 64'd0);

    // R2 R3 write/read sweep with garbage upper bits
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) begin
        logic [63:0] d;
        d = {32'hDEAD_BEEF, 8'hFF, 24'h0} ^ (64'(p) * 64'h0000_0000_0055_AA11 + 64'(i));
        wr(OFS[i], d);
      end
      check_state("R2 R3 readback");
    end

    // R2 unmapped address
    wr(12'h388, 64'hFFFF_FFFF);
    wr(12'h300, 64'h1234);
    check_state("R2 unmapped write ignored");
    @(negedge clk); addr = 12'h388; #1;
    chk("R2 unmapped read", rdata, 64'd0);
    @(negedge clk); addr = 12'h704; #1;
    chk("R2 unmapped read", rdata, 64'd0);

    // R4 R5 run through zero, all present
    wr(OFS[0], 64'hFF00_0000_FF00_0002);
    wr(OFS[1], 64'h0);
    wr(OFS[2], 64'h5);
    wr(OFS[3], 64'h1);
    present = 4'hF;
    for (int t = 0; t < 8; t++) tick_cycle(0, 0, '0);

    // R6 partial presence
    present = 4'b0101;
    for (int t = 0; t < 3; t++) tick_cycle(0, 0, '0);

    // R8 collision: write to CPU2 in the tick cycle
    present = 4'hF;
    tick_cycle(1, 2, 64'hFFFF_FFFF_FF00_0010);
    tick_cycle(1, 1, 64'h3);

    // R3 write clears overflow
    wr(OFS[0], 64'h0100_0007);
    check_state("R3 overflow cleared");
    tick_cycle(0, 0, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule